// File: doc/BRIEF.md
# Delayed SRAM Write Sequencer

This block lives inside a search coprocessor. It watches the host command port for a four-cycle write that targets the external associative-data SRAM. When the command is aimed at this device and is legal, the block presents the assembled address on the SRAM bus and pulses the write and address-latch strobes. It does this a programmable number of clocks after the second command cycle, so the SRAM write lines up with where a search result would land in the same pipeline.

A command has four cycles. Cycle A and cycle B both carry the command strobe and the write opcode. The two trailing cycles carry nothing the block uses. The host port has no ready signal and no back-pressure: the host must leave a command's two trailing cycles free before the next cycle A. The `busy` output tells it when a write is still in flight. Pending writes travel down a shift pipeline, so a new command may start while earlier ones are still waiting to reach the SRAM. The latency select must be held steady while `busy` is high.

Top module: `sram_wr_sequencer`

## Requirements
- R1: A command opens when `cmd_valid` is 1 and `cmd_word[1:0]` is 2'b01 in cycle A. It must show the same strobe and opcode in cycle B. If cycle A has any other opcode, no write is issued. If cycle B lacks the strobe or the opcode, the command is dropped and nothing is written.
- R2: A write is issued only when `host_dq[20:19]` equals 2'b10 in both cycle A and cycle B.
- R3: A write is issued only when `host_dq[25:21]` equals `dev_id` in both cycle A and cycle B.
- R4: The SRAM address is taken entirely from cycle A. `sram_addr[21:19]` comes from `cmd_word[8:6]` and `sram_addr[18:0]` comes from `host_dq[18:0]`. Cycle B values of these fields are not used.
- R5: If `cmd_word[2]` is 1 in cycle A or cycle B of an otherwise accepted command, no SRAM cycle is issued. Instead `burst_err` is high for exactly one clock, the clock after cycle B.
- R6: If cycle B is clock n, the write strobe is low in clock n+L. L is 4, 5, 6 or 7 for `lat_sel` values 0, 1, 2 and 3.
- R7: For an issued write, `sram_we_n` and `sram_ale_n` are low together for exactly one clock and `sram_oe_n` stays high. Between writes, `sram_addr` keeps the last written address.
- R8: The values of `host_dq`, `cmd_word` and `cmd_valid` during the two trailing cycles are ignored, even when they look like a new write.
- R9: `busy` is high from cycle B through clock max(n+2, n+L-1) for an issued write, and through n+2 for a command accepted in cycle B but not issued. It is high only during cycle B for a command dropped in cycle B. Otherwise it is low.
- R10: A synchronous active-high `rst` forces `sram_we_n`, `sram_ale_n` and `sram_oe_n` to 1, `sram_addr` to 0 and `busy` and `burst_err` to 0. It also discards any write still pending.
- R11: Commands sent back to back, each cycle A four clocks after the previous one, each produce their own write at their own n+L, in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cmd_valid | input | 1 | Host command strobe |
| cmd_word | input | 9 | Command field: opcode [1:0], burst flag [2], upper address [8:6] |
| host_dq | input | 68 | Host data/address bus: low address [18:0], target [20:19], device ID [25:21] |
| dev_id | input | 5 | Device ID strap |
| lat_sel | input | 2 | Latency select, L = 4 + lat_sel |
| sram_addr | output | 22 | SRAM address bus |
| sram_we_n | output | 1 | SRAM write enable, active low |
| sram_oe_n | output | 1 | SRAM output enable, active low |
| sram_ale_n | output | 1 | SRAM address latch enable, active low |
| busy | output | 1 | A command or pending write is in flight |
| burst_err | output | 1 | One-clock flag for a rejected burst write |

## Verification
The bench sweeps every opcode against every target code under each of the four latency settings. Commands go out back to back, so writes from consecutive commands overlap inside the pipeline. A design with an off-by-one tap would strobe a clock early or late. One that kept only one pending entry would lose the earlier of two overlapping writes.

Trailing cycles are filled with traffic that looks exactly like a fresh write, to catch a decoder that returns to idle too soon. Cycle B carries a different upper and lower address than cycle A, which exposes a design that captures the address in the wrong cycle.

Further cases drive the target, the ID or the burst flag wrong in only one of the two command cycles, abort a command in cycle B, and reset the block in the middle of a command. A design that checked only one cycle would issue a write it should refuse. A reset that missed the pipeline would let a stale write appear after reset.

// File: rtl/xsw_pkg.sv
package xsw_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_CMDB = 2'd1,
    ST_TR1  = 2'd2,
    ST_TR2  = 2'd3
  } dec_state_e;

  localparam int unsigned OPC_W     = 2;
  localparam int unsigned TGT_W     = 2;
  localparam int unsigned BURST_BIT = 2;

  localparam logic [OPC_W-1:0] OPC_WRITE = 2'b01;
  localparam logic [TGT_W-1:0] TGT_SRAM  = 2'b10;

endpackage

// File: rtl/xsw_cmd_decode.sv
module xsw_cmd_decode
  import xsw_pkg::*;
#(
  parameter int unsigned DQ_W   = 68,
  parameter int unsigned CMD_W  = 9,
  parameter int unsigned ID_W   = 5,
  parameter int unsigned ADDR_W = 22,
  parameter int unsigned HI_W   = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_valid,
  input  logic [CMD_W-1:0]  cmd_word,
  input  logic [DQ_W-1:0]   host_dq,
  input  logic [ID_W-1:0]   dev_id,
  output logic              iss_v,
  output logic [ADDR_W-1:0] iss_addr,
  output logic              burst_err,
  output logic              dec_busy
);

  localparam int unsigned LO_W   = ADDR_W - HI_W;
  localparam int unsigned TGT_LSB = LO_W;
  localparam int unsigned ID_LSB  = LO_W + TGT_W;
  localparam int unsigned HI_LSB  = CMD_W - HI_W;

  dec_state_e        state_q;
  logic              sel_a_q;
  logic              bur_a_q;
  logic [ADDR_W-1:0] addr_a_q;

  logic opc_hit;
  logic sel_hit;
  logic bur_bit;

  // Per-cycle qualifiers on the current host bus contents
  always_comb begin
    opc_hit = cmd_valid && (cmd_word[OPC_W-1:0] == OPC_WRITE);
    sel_hit = (host_dq[TGT_LSB +: TGT_W] == TGT_SRAM) &&
              (host_dq[ID_LSB +: ID_W] == dev_id);
    bur_bit = cmd_word[BURST_BIT];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_IDLE;
      sel_a_q   <= 1'b0;
      bur_a_q   <= 1'b0;
      addr_a_q  <= '0;
      iss_v     <= 1'b0;
      burst_err <= 1'b0;
    end else begin
      iss_v     <= 1'b0;
      burst_err <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (opc_hit) begin
            state_q  <= ST_CMDB;
            sel_a_q  <= sel_hit;
            bur_a_q  <= bur_bit;
            addr_a_q <= {cmd_word[HI_LSB +: HI_W], host_dq[LO_W-1:0]};
          end
        end
        ST_CMDB: begin
          if (opc_hit) begin
            state_q <= ST_TR1;
            if (sel_a_q && sel_hit) begin
              if (bur_a_q || bur_bit) burst_err <= 1'b1;
              else                    iss_v     <= 1'b1;
            end
          end else begin
            state_q <= ST_IDLE;
          end
        end
        ST_TR1:  state_q <= ST_TR2;
        ST_TR2:  state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // The captured address is stable from the clock after cycle B until the
  // next cycle A at the earliest, so the first pipeline stage reads it directly.
  assign iss_addr = addr_a_q;
  assign dec_busy = (state_q != ST_IDLE);

endmodule

// File: rtl/xsw_lat_pipe.sv
module xsw_lat_pipe #(
  parameter int unsigned ADDR_W   = 22,
  parameter int unsigned SEL_W    = 2,
  parameter int unsigned BASE_LAT = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_v,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic [SEL_W-1:0]  lat_sel,
  output logic              tap_v,
  output logic [ADDR_W-1:0] tap_addr,
  output logic              pend
);

  // Stage 0 is the decoder output; the output register adds one more clock.
  localparam int unsigned DEPTH = BASE_LAT + (1 << SEL_W) - 2;

  logic              v_r [DEPTH-1];
  logic [ADDR_W-1:0] a_r [DEPTH-1];

  logic              stg_v [DEPTH];
  logic [ADDR_W-1:0] stg_a [DEPTH];

  for (genvar i = 0; i < DEPTH - 1; i++) begin : g_stage
    if (i == 0) begin : g_head
      always_ff @(posedge clk) begin
        if (rst) v_r[i] <= 1'b0;
        else     v_r[i] <= in_v;
        a_r[i] <= in_addr;
      end
    end else begin : g_body
      always_ff @(posedge clk) begin
        if (rst) v_r[i] <= 1'b0;
        else     v_r[i] <= v_r[i-1];
        a_r[i] <= a_r[i-1];
      end
    end
  end

  always_comb begin
    stg_v[0] = in_v;
    stg_a[0] = in_addr;
    for (int j = 1; j < DEPTH; j++) begin
      stg_v[j] = v_r[j-1];
      stg_a[j] = a_r[j-1];
    end
  end

  int tap_idx;

  always_comb begin
    tap_idx  = int'(lat_sel) + int'(BASE_LAT) - 2;
    tap_v    = 1'b0;
    tap_addr = '0;
    pend     = 1'b0;
    for (int j = 0; j < DEPTH; j++) begin
      if (j == tap_idx) begin
        tap_v    = stg_v[j];
        tap_addr = stg_a[j];
      end
      if (j <= tap_idx) pend = pend | stg_v[j];
    end
  end

endmodule

// File: rtl/xsw_sram_drive.sv
module xsw_sram_drive #(
  parameter int unsigned ADDR_W = 22
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tap_v,
  input  logic [ADDR_W-1:0] tap_addr,
  output logic [ADDR_W-1:0] sram_addr,
  output logic              sram_we_n,
  output logic              sram_oe_n,
  output logic              sram_ale_n
);

  always_ff @(posedge clk) begin
    if (rst) begin
      sram_addr  <= '0;
      sram_we_n  <= 1'b1;
      sram_oe_n  <= 1'b1;
      sram_ale_n <= 1'b1;
    end else begin
      sram_oe_n <= 1'b1;
      if (tap_v) begin
        sram_addr  <= tap_addr;
        sram_we_n  <= 1'b0;
        sram_ale_n <= 1'b0;
      end else begin
        sram_we_n  <= 1'b1;
        sram_ale_n <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/sram_wr_sequencer.sv
module sram_wr_sequencer #(
  parameter int unsigned DQ_W     = 68,
  parameter int unsigned CMD_W    = 9,
  parameter int unsigned ID_W     = 5,
  parameter int unsigned ADDR_W   = 22,
  parameter int unsigned HI_W     = 3,
  parameter int unsigned SEL_W    = 2,
  parameter int unsigned BASE_LAT = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_valid,
  input  logic [CMD_W-1:0]  cmd_word,
  input  logic [DQ_W-1:0]   host_dq,
  input  logic [ID_W-1:0]   dev_id,
  input  logic [SEL_W-1:0]  lat_sel,
  output logic [ADDR_W-1:0] sram_addr,
  output logic              sram_we_n,
  output logic              sram_oe_n,
  output logic              sram_ale_n,
  output logic              busy,
  output logic              burst_err
);

  logic              iss_v;
  logic [ADDR_W-1:0] iss_addr;
  logic              dec_busy;
  logic              tap_v;
  logic [ADDR_W-1:0] tap_addr;
  logic              pend;

  xsw_cmd_decode #(
    .DQ_W(DQ_W), .CMD_W(CMD_W), .ID_W(ID_W), .ADDR_W(ADDR_W), .HI_W(HI_W)
  ) u_dec (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_word(cmd_word),
    .host_dq(host_dq), .dev_id(dev_id), .iss_v(iss_v), .iss_addr(iss_addr),
    .burst_err(burst_err), .dec_busy(dec_busy)
  );

  xsw_lat_pipe #(
    .ADDR_W(ADDR_W), .SEL_W(SEL_W), .BASE_LAT(BASE_LAT)
  ) u_pipe (
    .clk(clk), .rst(rst), .in_v(iss_v), .in_addr(iss_addr),
    .lat_sel(lat_sel), .tap_v(tap_v), .tap_addr(tap_addr), .pend(pend)
  );

  xsw_sram_drive #(
    .ADDR_W(ADDR_W)
  ) u_drv (
    .clk(clk), .rst(rst), .tap_v(tap_v), .tap_addr(tap_addr),
    .sram_addr(sram_addr), .sram_we_n(sram_we_n), .sram_oe_n(sram_oe_n),
    .sram_ale_n(sram_ale_n)
  );

  assign busy = dec_busy | pend;

endmodule

// File: rtl/xsw_chk.sv
module xsw_chk #(
  parameter int unsigned ADDR_W = 22
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] sram_addr,
  input logic              sram_we_n,
  input logic              sram_oe_n,
  input logic              sram_ale_n,
  input logic              busy,
  input logic              burst_err
);

  AST_STROBE_PAIR: assert property (@(posedge clk) disable iff (rst)
    sram_we_n == sram_ale_n); // R7
  AST_WE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    !sram_we_n |=> sram_we_n); // R7
  AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (rst)
    sram_we_n |-> $stable(sram_addr)); // R7
  AST_OE_DURING_WRITE: assert property (@(posedge clk) disable iff (rst)
    !sram_we_n |-> sram_oe_n); // R7
  AST_WE_AFTER_BUSY: assert property (@(posedge clk) disable iff (rst)
    !sram_we_n |-> $past(busy)); // R6
  AST_ERR_PULSE: assert property (@(posedge clk) disable iff (rst)
    burst_err |=> !burst_err); // R5
  AST_ERR_BUSY: assert property (@(posedge clk) disable iff (rst)
    burst_err |-> $past(busy)); // R5
  AST_RESET_QUIET: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (sram_we_n && !busy && !burst_err)); // R10

endmodule

bind sram_wr_sequencer xsw_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .sram_addr(sram_addr), .sram_we_n(sram_we_n),
  .sram_oe_n(sram_oe_n), .sram_ale_n(sram_ale_n), .busy(busy),
  .burst_err(burst_err)
);

// File: tb/tb_sram_wr_sequencer.sv
module tb_sram_wr_sequencer;

  localparam int NCYC = 4096;
  localparam logic [4:0] DEV = 5'd19;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cmd_valid = 1'b0;
  logic [8:0]  cmd_word = '0;
  logic [67:0] host_dq = '0;
  logic [4:0]  dev_id = DEV;
  logic [1:0]  lat_sel = 2'd0;
  logic [21:0] sram_addr;
  logic        sram_we_n, sram_oe_n, sram_ale_n, busy, burst_err;

  sram_wr_sequencer dut (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_word(cmd_word),
    .host_dq(host_dq), .dev_id(dev_id), .lat_sel(lat_sel),
    .sram_addr(sram_addr), .sram_we_n(sram_we_n), .sram_oe_n(sram_oe_n),
    .sram_ale_n(sram_ale_n), .busy(busy), .burst_err(burst_err)
  );

  always #4 clk = ~clk;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  bit chk_en = 0;
  bit done = 0;
  int unsigned seed = 32'h1234_5678;
  logic [21:0] last_addr = '0;

  bit          exp_we   [0:NCYC-1];
  bit          exp_busy [0:NCYC-1];
  bit          exp_err  [0:NCYC-1];
  logic [21:0] exp_addr [0:NCYC-1];
  string       exp_tag  [0:NCYC-1];

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h (cycle %0d)", req, what, act, exp, cyc);
    end
  endtask

  function automatic logic [31:0] rnd();
    seed = seed * 32'd1103515245 + 32'd12345;
    return seed;
  endfunction

  // Monitor: samples two time units after each rising edge
  always @(posedge clk) begin
    #2;
    if (rst) last_addr = '0;
    if (chk_en && !rst && cyc < NCYC) begin
      string t;
      logic [21:0] ea;
      t  = (exp_tag[cyc] == "") ? "R6" : exp_tag[cyc];
      ea = exp_we[cyc] ? exp_addr[cyc] : last_addr;
      chk(sram_we_n == !exp_we[cyc], t, "we_n", 32'(sram_we_n), 32'(!exp_we[cyc]));
      chk(sram_ale_n == !exp_we[cyc], "R7", "ale_n", 32'(sram_ale_n), 32'(!exp_we[cyc]));
      chk(sram_oe_n == 1'b1, "R7", "oe_n", 32'(sram_oe_n), 32'd1);
      chk(sram_addr == ea, exp_we[cyc] ? "R4" : "R7", "addr", 32'(sram_addr), 32'(ea));
      chk(busy == exp_busy[cyc], "R9", "busy", 32'(busy), 32'(exp_busy[cyc]));
      chk(burst_err == exp_err[cyc], "R5", "burst_err", 32'(burst_err), 32'(exp_err[cyc]));
      if (exp_we[cyc]) last_addr = exp_addr[cyc];
    end
  end

  function automatic void mark_busy(input int i);
    if (i < NCYC) exp_busy[i] = 1'b1;
  endfunction

  // One four-cycle command. Cycle A is driven in clock a; cycle B is c = a+1.
  task automatic send(input int op_a, input int op_b, input bit vld_b,
                      input int tgt_a, input int tgt_b,
                      input logic [4:0] id_a, input logic [4:0] id_b,
                      input bit bur_a, input bit bur_b,
                      input logic [2:0] hi, input logic [18:0] lo,
                      input bit noise, input bit record, input string tag);
    int c, lat;
    bit acc_a, acc_b, ok, iss, err;
    @(negedge clk);
    c     = cyc + 1;
    lat   = 4 + int'(lat_sel);
    acc_a = (op_a == 1);
    acc_b = acc_a && vld_b && (op_b == 1);
    ok    = acc_b && tgt_a == 2 && tgt_b == 2 && id_a == DEV && id_b == DEV;
    iss   = ok && !bur_a && !bur_b;
    err   = ok && (bur_a || bur_b);
    if (record) begin
      if (acc_a) mark_busy(c);
      if (acc_b) begin mark_busy(c + 1); mark_busy(c + 2); end
      if (iss) for (int k = c; k < c + lat; k++) mark_busy(k);
      if (err && c + 1 < NCYC) exp_err[c + 1] = 1'b1;
      if (c + lat < NCYC) begin
        exp_tag[c + lat] = tag;
        if (iss) begin
          exp_we[c + lat]   = 1'b1;
          exp_addr[c + lat] = {hi, lo};
        end
      end
    end
    // cycle A
    cmd_valid = 1'b1;
    cmd_word  = {hi, 3'b101, bur_a, 2'(op_a)};
    host_dq   = {10'(rnd()), rnd(), id_a, 2'(tgt_a), lo};
    // cycle B: different address fields, which must be ignored (R4)
    @(negedge clk);
    cmd_valid = vld_b;
    cmd_word  = {~hi, 3'b010, bur_b, 2'(op_b)};
    host_dq   = {10'(rnd()), rnd(), id_b, 2'(tgt_b), ~lo};
    // trailing cycles (R8)
    for (int t = 0; t < 2; t++) begin
      @(negedge clk);
      if (noise) begin
        cmd_valid = 1'b1;
        cmd_word  = {3'(rnd()), 3'b000, 1'b0, 2'b01};
        host_dq   = {10'(rnd()), rnd(), DEV, 2'b10, 19'(rnd())};
      end else begin
        cmd_valid = 1'b0;
        cmd_word  = 9'(rnd());
        host_dq   = {4'(rnd()), rnd(), rnd()};
      end
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      cmd_valid = 1'b0;
      cmd_word  = 9'(rnd());
      host_dq   = {4'(rnd()), rnd(), rnd()};
    end
  endtask

  initial begin
    for (int i = 0; i < NCYC; i++) begin
      exp_we[i] = 0; exp_busy[i] = 0; exp_err[i] = 0; exp_addr[i] = '0; exp_tag[i] = "";
    end
    // R10: a command presented during reset must be ignored
    repeat (2) @(negedge clk);
    cmd_valid = 1'b1;
    cmd_word  = 9'h001;
    host_dq   = {42'd0, DEV, 2'b10, 19'h00055};
    repeat (2) @(negedge clk);
    cmd_valid = 1'b0;
    @(negedge clk);
    chk(sram_we_n && sram_ale_n && sram_oe_n, "R10", "strobes in reset",
        {29'd0, sram_we_n, sram_ale_n, sram_oe_n}, 32'd7);
    chk(sram_addr == '0, "R10", "addr in reset", 32'(sram_addr), 32'd0);
    chk(!busy && !burst_err, "R10", "busy/err in reset", {30'd0, busy, burst_err}, 32'd0);
    rst = 1'b0;
    chk_en = 1'b1;
    idle(3);

    // Sweep: every latency x every opcode x every target code, back to back
    for (int l = 0; l < 4; l++) begin
      lat_sel = 2'(l);
      for (int op = 0; op < 4; op++) begin
        for (int tg = 0; tg < 4; tg++) begin
          string tag;
          bit nz;
          nz  = (op == 1) && ((tg + l) % 2 == 1);
          if (op != 1)      tag = "R1";
          else if (tg != 2) tag = "R2";
          else if (nz)      tag = "R8";
          else              tag = "R11";
          send(op, op, 1'b1, tg, tg, DEV, DEV, 1'b0, 1'b0,
               3'(op * 3 + tg + l), 19'(rnd()), nz, 1'b1, tag);
        end
      end
      // Corner cases under this latency
      send(1, 1, 1'b1, 2, 2, DEV, DEV, 1'b0, 1'b0, 3'h7, 19'h7FFFF, 1'b0, 1'b1, "R6");
      send(1, 1, 1'b1, 2, 2, DEV, DEV, 1'b0, 1'b0, 3'h0, 19'h00000, 1'b0, 1'b1, "R6");
      send(1, 1, 1'b1, 2, 2, DEV ^ 5'd1, DEV, 1'b0, 1'b0, 3'h2, 19'h12345, 1'b0, 1'b1, "R3");
      send(1, 1, 1'b1, 2, 2, DEV, DEV ^ 5'd16, 1'b0, 1'b0, 3'h3, 19'h23456, 1'b0, 1'b1, "R3");
      send(1, 1, 1'b1, 2, 3, DEV, DEV, 1'b0, 1'b0, 3'h4, 19'h34567, 1'b0, 1'b1, "R2");
      send(1, 1, 1'b1, 2, 2, DEV, DEV, 1'b1, 1'b0, 3'h5, 19'h45678, 1'b0, 1'b1, "R5");
      send(1, 1, 1'b1, 2, 2, DEV, DEV, 1'b0, 1'b1, 3'h6, 19'h56789, 1'b0, 1'b1, "R5");
      send(1, 1, 1'b0, 2, 2, DEV, DEV, 1'b0, 1'b0, 3'h1, 19'h6789A, 1'b0, 1'b1, "R1");
      send(1, 2, 1'b1, 2, 2, DEV, DEV, 1'b0, 1'b0, 3'h1, 19'h789AB, 1'b0, 1'b1, "R1");
      send(1, 1, 1'b1, 2, 2, DEV, DEV, 1'b0, 1'b0, 3'h5, 19'h0F0F0, 1'b1, 1'b1, "R8");
      idle(10);
    end

    // R10: reset in the middle of a command discards the pending write
    chk_en = 1'b0;
    lat_sel = 2'd3;
    @(negedge clk);
    cmd_valid = 1'b1; cmd_word = 9'h1C1; host_dq = {42'd0, DEV, 2'b10, 19'h11111};
    @(negedge clk);
    cmd_valid = 1'b1; cmd_word = 9'h001; host_dq = {42'd0, DEV, 2'b10, 19'h11111};
    @(negedge clk);
    cmd_valid = 1'b0; rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      chk(sram_we_n && sram_ale_n, "R10", "no write after reset",
          {30'd0, sram_we_n, sram_ale_n}, 32'd3);
      chk(!busy && sram_addr == '0, "R10", "busy/addr after reset",
          {9'd0, busy, sram_addr}, 32'd0);
    end

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule